// File: doc/BRIEF.md
# Equaliser Bandwidth Step Sequencer

This controller shortens the settling of a receiver equaliser's adaptation loops by narrowing their bandwidth in four timed steps. An external timer raises four one-cycle gear pulses, one per step. For each pulse the sequencer builds read-modify-write requests (register address, bit mask and new field value) for a separate port engine. It also drives the hold inputs of the gain-control loop and of the high-frequency and low-frequency compensation loops.

The operating mode is sampled once after reset. In decision-feedback mode each gear retunes only the gain-control loop, and the two frequency loops are frozen from the start. In low-power mode each gear retunes the high-frequency loop first and then the low-frequency loop, and the second request waits for the first to finish. When the fourth gear's work is done, all three loops are frozen. The sequencer then stays idle until the next reset. The register addresses, field positions and per-gear bandwidth codes are parameters.

Top module: `eqseq_top`

## Requirements
- R1: While reset is asserted, all three hold outputs and `req_valid_o` are low.
- R2: In the first cycle after reset the mode is sampled (0 = decision-feedback, 1 = low-power). In decision-feedback mode `hold_hf_o` and `hold_lf_o` go high and stay high. `hold_gain_o` stays low. In low-power mode all holds stay low.
- R3: In decision-feedback mode gear n (bit n-1 of `gear_i`) gives exactly one request to the gain register (default address 0x04C, mask 0x00F0). Its value is code n shifted to bit 4. The default codes are log2 of the multiplier: 64x=6, 16x=4, 4x=2, 1x=0.
- R4: In low-power mode each gear gives two requests. The high-frequency request comes first (default address 0x062, mask 0x000F, value at bit 0). The low-frequency request follows (default address 0x063, mask 0x0F00, value at bit 8). The default codes for both loops are 16x=4, 8x=3, 4x=2, 1x=0.
- R5: A new request is raised only after the engine has pulsed `rmw_done_i` for the previous one.
- R6: `req_valid_o` is never high while `rmw_busy_i` is high, and it lasts exactly one cycle per request.
- R7: A gear pulse that arrives while an update is in progress is kept and served later, never lost.
- R8: Pending gears are served lowest-numbered first.
- R9: In the cycle after `rmw_done_i` of the final gear's last request, all three holds are high. `hold_gain_o` is low before that point.
- R10: After the final gear completes, further gear pulses raise no request, and all holds stay high until reset.
- R11: Reset from the final state lowers all holds.
- R12: Changing `mode_i` after the first cycle following reset has no effect on the request sequence.
- R13: The request to the engine is raised two cycles after a gear pulse is sampled, provided the sequencer is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 1 | 0 = decision-feedback, 1 = low-power; sampled after reset |
| gear_i | input | 4 | One-cycle gear pulses, bit 0 = widest step |
| rmw_busy_i | input | 1 | Engine cannot accept a request |
| rmw_done_i | input | 1 | One-cycle pulse: engine finished the current request |
| req_valid_o | output | 1 | One-cycle request strobe |
| req_addr_o | output | 9 | Register address of the request |
| req_mask_o | output | 16 | Bits to replace |
| req_value_o | output | 16 | New field value, aligned to the mask |
| hold_gain_o | output | 1 | Freeze gain-control loop |
| hold_hf_o | output | 1 | Freeze high-frequency loop |
| hold_lf_o | output | 1 | Freeze low-frequency loop |

## Verification
A gear pulse is registered at one edge. The state machine leaves idle at the next edge, so the request strobe is visible in the second cycle after the pulse. The bench samples at the falling edge two cycles after driving the pulse. Holds change in the cycle after the engine's done pulse, and the start-up holds change in the first cycle after reset release. The bench's engine model records every request at the rising edge, and checks compare those records in order. Any check that depends on engine latency first waits for the record count, then samples.

// File: rtl/eqseq_pkg.sv
package eqseq_pkg;

    typedef enum logic [2:0] {
        ST_START,
        ST_IDLE,
        ST_ISSUE,
        ST_WAIT,
        ST_END
    } seq_state_e;

    typedef enum logic [1:0] {
        LOOP_GAIN,
        LOOP_HF,
        LOOP_LF
    } loop_e;

    typedef enum logic {
        MODE_DFE = 1'b0,
        MODE_LPM = 1'b1
    } mode_e;

    localparam int NUM_LOOPS = 3;

endpackage

// File: rtl/eqseq_gear_queue.sv
module eqseq_gear_queue #(
    parameter int NUM_GEARS = 4,
    localparam int IDX_W = (NUM_GEARS > 1) ? $clog2(NUM_GEARS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_GEARS-1:0] gear_i,
    input  logic                 take_i,
    input  logic [IDX_W-1:0]     take_idx_i,
    output logic                 any_o,
    output logic [IDX_W-1:0]     first_idx_o
);

    logic [NUM_GEARS-1:0] pend_d, pend_q;
    logic [NUM_GEARS-1:0] clr_mask;

    // one-hot clear mask for the gear being served
    always_comb begin
        clr_mask = '0;
        if (take_i) clr_mask[take_idx_i] = 1'b1;
        pend_d = (pend_q & ~clr_mask) | gear_i;
    end

    // lowest pending gear wins
    always_comb begin
        first_idx_o = '0;
        for (int i = NUM_GEARS - 1; i >= 0; i--) begin
            if (pend_q[i]) first_idx_o = IDX_W'(i);
        end
        any_o = |pend_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= pend_d;
    end

endmodule

// File: rtl/eqseq_field_lut.sv
module eqseq_field_lut
    import eqseq_pkg::*;
#(
    parameter int NUM_GEARS = 4,
    parameter int ADDR_W    = 9,
    parameter int DATA_W    = 16,
    parameter int CODE_W    = 4,
    parameter logic [ADDR_W-1:0] GAIN_ADDR = 9'h04C,
    parameter int GAIN_LSB = 4,
    parameter logic [NUM_GEARS*CODE_W-1:0] GAIN_CODES = {4'd0, 4'd2, 4'd4, 4'd6},
    parameter logic [ADDR_W-1:0] HF_ADDR = 9'h062,
    parameter int HF_LSB = 0,
    parameter logic [NUM_GEARS*CODE_W-1:0] HF_CODES = {4'd0, 4'd2, 4'd3, 4'd4},
    parameter logic [ADDR_W-1:0] LF_ADDR = 9'h063,
    parameter int LF_LSB = 8,
    parameter logic [NUM_GEARS*CODE_W-1:0] LF_CODES = {4'd0, 4'd2, 4'd3, 4'd4},
    localparam int IDX_W = (NUM_GEARS > 1) ? $clog2(NUM_GEARS) : 1
) (
    input  loop_e              loop_i,
    input  logic [IDX_W-1:0]   gear_i,
    output logic [ADDR_W-1:0]  addr_o,
    output logic [DATA_W-1:0]  mask_o,
    output logic [DATA_W-1:0]  value_o
);

    localparam logic [DATA_W-1:0] FIELD_ONES = DATA_W'((1 << CODE_W) - 1);
    localparam logic [DATA_W-1:0] GAIN_MASK  = FIELD_ONES << GAIN_LSB;
    localparam logic [DATA_W-1:0] HF_MASK    = FIELD_ONES << HF_LSB;
    localparam logic [DATA_W-1:0] LF_MASK    = FIELD_ONES << LF_LSB;

    logic [DATA_W-1:0] gain_val [NUM_GEARS];
    logic [DATA_W-1:0] hf_val   [NUM_GEARS];
    logic [DATA_W-1:0] lf_val   [NUM_GEARS];

    // per-gear aligned field values
    for (genvar g = 0; g < NUM_GEARS; g++) begin : g_gear
        assign gain_val[g] = DATA_W'(GAIN_CODES[g*CODE_W +: CODE_W]) << GAIN_LSB;
        assign hf_val[g]   = DATA_W'(HF_CODES[g*CODE_W +: CODE_W]) << HF_LSB;
        assign lf_val[g]   = DATA_W'(LF_CODES[g*CODE_W +: CODE_W]) << LF_LSB;
    end

    always_comb begin
        case (loop_i)
            LOOP_HF: begin
                addr_o  = HF_ADDR;
                mask_o  = HF_MASK;
                value_o = hf_val[gear_i];
            end
            LOOP_LF: begin
                addr_o  = LF_ADDR;
                mask_o  = LF_MASK;
                value_o = lf_val[gear_i];
            end
            default: begin
                addr_o  = GAIN_ADDR;
                mask_o  = GAIN_MASK;
                value_o = gain_val[gear_i];
            end
        endcase
    end

endmodule

// File: rtl/eqseq_ctrl.sv
module eqseq_ctrl
    import eqseq_pkg::*;
#(
    parameter int NUM_GEARS = 4,
    localparam int IDX_W = (NUM_GEARS > 1) ? $clog2(NUM_GEARS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_i,
    input  logic             any_pend_i,
    input  logic [IDX_W-1:0] first_idx_i,
    input  logic             busy_i,
    input  logic             done_i,
    output logic             take_o,
    output logic             req_o,
    output loop_e            loop_o,
    output logic [IDX_W-1:0] gear_o,
    output logic             hold_gain_o,
    output logic             hold_hf_o,
    output logic             hold_lf_o
);

    localparam logic [IDX_W-1:0] LAST_GEAR = IDX_W'(NUM_GEARS - 1);

    typedef struct packed {
        seq_state_e       st;
        mode_e            mode;
        loop_e            loop;
        logic [IDX_W-1:0] gear;
        logic             hold_gain;
        logic             hold_hf;
        logic             hold_lf;
    } ctrl_t;

    localparam ctrl_t CTRL_RST = '{
        st: ST_START, mode: MODE_DFE, loop: LOOP_GAIN, gear: '0,
        hold_gain: 1'b0, hold_hf: 1'b0, hold_lf: 1'b0
    };

    ctrl_t ctl_d, ctl_q;
    logic  take_d, req_d;

    always_comb begin
        ctl_d  = ctl_q;
        take_d = 1'b0;
        req_d  = 1'b0;
        case (ctl_q.st)
            ST_START: begin
                ctl_d.mode = mode_e'(mode_i);
                if (mode_e'(mode_i) == MODE_DFE) begin
                    ctl_d.hold_hf = 1'b1;
                    ctl_d.hold_lf = 1'b1;
                end
                ctl_d.st = ST_IDLE;
            end
            ST_IDLE: begin
                if (any_pend_i) begin
                    take_d     = 1'b1;
                    ctl_d.gear = first_idx_i;
                    ctl_d.loop = (ctl_q.mode == MODE_LPM) ? LOOP_HF : LOOP_GAIN;
                    ctl_d.st   = ST_ISSUE;
                end
            end
            ST_ISSUE: begin
                if (!busy_i) begin
                    req_d    = 1'b1;
                    ctl_d.st = ST_WAIT;
                end
            end
            ST_WAIT: begin
                if (done_i) begin
                    if (ctl_q.mode == MODE_LPM && ctl_q.loop == LOOP_HF) begin
                        ctl_d.loop = LOOP_LF;
                        ctl_d.st   = ST_ISSUE;
                    end else if (ctl_q.gear == LAST_GEAR) begin
                        ctl_d.hold_gain = 1'b1;
                        ctl_d.hold_hf   = 1'b1;
                        ctl_d.hold_lf   = 1'b1;
                        ctl_d.st        = ST_END;
                    end else begin
                        ctl_d.st = ST_IDLE;
                    end
                end
            end
            ST_END: ctl_d.st = ST_END;
            default: ctl_d = CTRL_RST;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= CTRL_RST;
        else        ctl_q <= ctl_d;
    end

    assign take_o      = take_d;
    assign req_o       = req_d;
    assign loop_o      = ctl_q.loop;
    assign gear_o      = ctl_q.gear;
    assign hold_gain_o = ctl_q.hold_gain;
    assign hold_hf_o   = ctl_q.hold_hf;
    assign hold_lf_o   = ctl_q.hold_lf;

endmodule

// File: rtl/eqseq_top.sv
module eqseq_top
    import eqseq_pkg::*;
#(
    parameter int NUM_GEARS = 4,
    parameter int ADDR_W    = 9,
    parameter int DATA_W    = 16,
    parameter int CODE_W    = 4,
    parameter logic [ADDR_W-1:0] GAIN_ADDR = 9'h04C,
    parameter int GAIN_LSB = 4,
    parameter logic [NUM_GEARS*CODE_W-1:0] GAIN_CODES = {4'd0, 4'd2, 4'd4, 4'd6},
    parameter logic [ADDR_W-1:0] HF_ADDR = 9'h062,
    parameter int HF_LSB = 0,
    parameter logic [NUM_GEARS*CODE_W-1:0] HF_CODES = {4'd0, 4'd2, 4'd3, 4'd4},
    parameter logic [ADDR_W-1:0] LF_ADDR = 9'h063,
    parameter int LF_LSB = 8,
    parameter logic [NUM_GEARS*CODE_W-1:0] LF_CODES = {4'd0, 4'd2, 4'd3, 4'd4}
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 mode_i,
    input  logic [NUM_GEARS-1:0] gear_i,
    input  logic                 rmw_busy_i,
    input  logic                 rmw_done_i,
    output logic                 req_valid_o,
    output logic [ADDR_W-1:0]    req_addr_o,
    output logic [DATA_W-1:0]    req_mask_o,
    output logic [DATA_W-1:0]    req_value_o,
    output logic                 hold_gain_o,
    output logic                 hold_hf_o,
    output logic                 hold_lf_o
);

    localparam int IDX_W = (NUM_GEARS > 1) ? $clog2(NUM_GEARS) : 1;

    logic             any_pend;
    logic [IDX_W-1:0] first_idx;
    logic             take;
    loop_e            cur_loop;
    logic [IDX_W-1:0] cur_gear;

    eqseq_gear_queue #(.NUM_GEARS(NUM_GEARS)) u_queue (
        .clk        (clk),
        .rst_n      (rst_n),
        .gear_i     (gear_i),
        .take_i     (take),
        .take_idx_i (first_idx),
        .any_o      (any_pend),
        .first_idx_o(first_idx)
    );

    eqseq_ctrl #(.NUM_GEARS(NUM_GEARS)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_i     (mode_i),
        .any_pend_i (any_pend),
        .first_idx_i(first_idx),
        .busy_i     (rmw_busy_i),
        .done_i     (rmw_done_i),
        .take_o     (take),
        .req_o      (req_valid_o),
        .loop_o     (cur_loop),
        .gear_o     (cur_gear),
        .hold_gain_o(hold_gain_o),
        .hold_hf_o  (hold_hf_o),
        .hold_lf_o  (hold_lf_o)
    );

    eqseq_field_lut #(
        .NUM_GEARS (NUM_GEARS),
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W),
        .CODE_W    (CODE_W),
        .GAIN_ADDR (GAIN_ADDR),
        .GAIN_LSB  (GAIN_LSB),
        .GAIN_CODES(GAIN_CODES),
        .HF_ADDR   (HF_ADDR),
        .HF_LSB    (HF_LSB),
        .HF_CODES  (HF_CODES),
        .LF_ADDR   (LF_ADDR),
        .LF_LSB    (LF_LSB),
        .LF_CODES  (LF_CODES)
    ) u_lut (
        .loop_i (cur_loop),
        .gear_i (cur_gear),
        .addr_o (req_addr_o),
        .mask_o (req_mask_o),
        .value_o(req_value_o)
    );

endmodule

// File: rtl/eqseq_chk.sv
module eqseq_chk #(
    parameter int ADDR_W = 9,
    parameter logic [ADDR_W-1:0] GAIN_ADDR = 9'h04C
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rmw_busy_i,
    input logic              rmw_done_i,
    input logic              req_valid_o,
    input logic [ADDR_W-1:0] req_addr_o,
    input logic              hold_gain_o,
    input logic              hold_hf_o,
    input logic              hold_lf_o
);

    logic outstanding_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           outstanding_q <= 1'b0;
        else if (req_valid_o) outstanding_q <= 1'b1;
        else if (rmw_done_i)  outstanding_q <= 1'b0;
    end

    // R5
    one_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid_o |-> !outstanding_q);

    // R6
    no_req_when_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid_o |-> !rmw_busy_i);

    // R6
    single_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid_o |=> !req_valid_o);

    // R9
    final_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hold_gain_o |-> (hold_hf_o && hold_lf_o));

    // R10
    holds_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hold_gain_o |=> (hold_gain_o && hold_hf_o && hold_lf_o));

    // R10
    quiet_after_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hold_gain_o |-> !req_valid_o);

    // R2
    hf_hold_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hold_hf_o |=> hold_hf_o);

    // R3
    dfe_gain_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_o && hold_hf_o) |-> (req_addr_o == GAIN_ADDR));

endmodule

bind eqseq_top eqseq_chk #(.ADDR_W(ADDR_W), .GAIN_ADDR(GAIN_ADDR)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rmw_busy_i (rmw_busy_i),
    .rmw_done_i (rmw_done_i),
    .req_valid_o(req_valid_o),
    .req_addr_o (req_addr_o),
    .hold_gain_o(hold_gain_o),
    .hold_hf_o  (hold_hf_o),
    .hold_lf_o  (hold_lf_o)
);

// File: tb/tb_eqseq_top.sv
`timescale 1ns/1ps
module tb_eqseq_top;

    localparam int LAT = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode_i = 1'b0;
    logic [3:0]  gear_i = '0;
    logic        eng_busy = 1'b0, ext_busy = 1'b0, rmw_done = 1'b0;
    logic        rmw_busy;
    logic        req_valid;
    logic [8:0]  req_addr;
    logic [15:0] req_mask, req_value;
    logic        hold_gain, hold_hf, hold_lf;

    int checks = 0, errors = 0, cyc = 0;
    int cap_n = 0, overlap = 0, eng_cnt = 0;
    logic [40:0] cap [64];

    always #4 clk = ~clk;
    assign rmw_busy = eng_busy | ext_busy;

    eqseq_top dut (
        .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .gear_i(gear_i),
        .rmw_busy_i(rmw_busy), .rmw_done_i(rmw_done),
        .req_valid_o(req_valid), .req_addr_o(req_addr), .req_mask_o(req_mask),
        .req_value_o(req_value), .hold_gain_o(hold_gain), .hold_hf_o(hold_hf),
        .hold_lf_o(hold_lf)
    );

    // engine model: records each request, answers after LAT cycles
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            eng_busy <= 1'b0; eng_cnt <= 0; rmw_done <= 1'b0;
        end else begin
            rmw_done <= 1'b0;
            if (req_valid) begin
                if (eng_busy || eng_cnt != 0) overlap <= overlap + 1;
                cap[cap_n[5:0]] <= {req_addr, req_mask, req_value};
                cap_n    <= cap_n + 1;
                eng_busy <= 1'b1;
                eng_cnt  <= LAT;
            end else if (eng_cnt != 0) begin
                eng_cnt <= eng_cnt - 1;
                if (eng_cnt == 1) begin
                    rmw_done <= 1'b1;
                    eng_busy <= 1'b0;
                end
            end
        end
    end

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 50000) begin
            checks++; errors++;
            $display("FAIL watchdog act=%0d exp=<50000", cyc);
            summary();
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic pulse(input logic [3:0] m);
        @(negedge clk) gear_i = m;
        @(negedge clk) gear_i = '0;
    endtask

    task automatic wait_caps(input int n);
        for (int t = 0; t < 400 && cap_n < n; t++) @(negedge clk);
    endtask

    task automatic do_reset(input logic m);
        @(negedge clk) rst_n = 1'b0; mode_i = m;
        @(negedge clk);
        chk("R1 holds in reset", {hold_gain, hold_hf, hold_lf, req_valid}, 64'h0);
        @(negedge clk) rst_n = 1'b1;
        @(negedge clk);
        if (!m) chk("R2 dfe start holds", {hold_gain, hold_hf, hold_lf}, 64'b011);
        else    chk("R2 lpm start holds", {hold_gain, hold_hf, hold_lf}, 64'b000);
    endtask

    // {mode, gear index, addr, mask, value}
    localparam logic [43:0] VEC [12] = '{
        {1'b0, 2'd0, 9'h04C, 16'h00F0, 16'h0060},
        {1'b0, 2'd1, 9'h04C, 16'h00F0, 16'h0040},
        {1'b0, 2'd2, 9'h04C, 16'h00F0, 16'h0020},
        {1'b0, 2'd3, 9'h04C, 16'h00F0, 16'h0000},
        {1'b1, 2'd0, 9'h062, 16'h000F, 16'h0004},
        {1'b1, 2'd0, 9'h063, 16'h0F00, 16'h0400},
        {1'b1, 2'd1, 9'h062, 16'h000F, 16'h0003},
        {1'b1, 2'd1, 9'h063, 16'h0F00, 16'h0300},
        {1'b1, 2'd2, 9'h062, 16'h000F, 16'h0002},
        {1'b1, 2'd2, 9'h063, 16'h0F00, 16'h0200},
        {1'b1, 2'd3, 9'h062, 16'h000F, 16'h0000},
        {1'b1, 2'd3, 9'h063, 16'h0F00, 16'h0000}
    };

    initial begin
        int exp_n;
        exp_n = 0;
        for (int i = 0; i < 12; i++) begin
            logic vmode;
            logic [1:0] vg;
            vmode = VEC[i][43];
            vg    = VEC[i][42:41];
            if (i == 0) do_reset(1'b0);
            if (i == 4) begin
                do_reset(1'b1);
                mode_i = 1'b0; // R12: late change must be ignored
            end
            // first request of a gear needs a pulse; LF follows HF by itself
            if (!vmode || VEC[i][40:32] == 9'h062) begin
                pulse(4'b0001 << vg);
                if (i == 0) begin
                    @(negedge clk);
                    chk("R13 request latency", req_valid, 1);
                end
            end
            exp_n++;
            wait_caps(exp_n);
            chk(vmode ? "R4 lpm request" : "R3 dfe request", cap[exp_n-1], VEC[i][40:0]);
            if (i == 2) begin
                repeat (LAT + 3) @(negedge clk);
                chk("R9 gain hold still low", hold_gain, 0);
            end
            if (i == 3 || i == 11) begin
                for (int t = 0; t < 20 && !rmw_done; t++) @(negedge clk);
                @(negedge clk);
                chk("R9 all holds after last done", {hold_gain, hold_hf, hold_lf}, 64'b111);
            end
            if (i == 3) begin
                pulse(4'b0001);
                repeat (10) @(negedge clk);
                chk("R10 no request after end", cap_n, exp_n);
                chk("R10 holds stay", {hold_gain, hold_hf, hold_lf}, 64'b111);
                @(negedge clk) rst_n = 1'b0;
                @(negedge clk);
                chk("R11 reset clears holds", {hold_gain, hold_hf, hold_lf}, 64'b000);
            end
        end
        chk("R5 no overlapping requests", overlap, 0);

        // R7 / R8: pulses during an update, out of order
        do_reset(1'b0);
        pulse(4'b0001);
        @(negedge clk);
        pulse(4'b0100);
        pulse(4'b0010);
        wait_caps(exp_n + 3);
        chk("R7 first served", cap[exp_n], {9'h04C, 16'h00F0, 16'h0060});
        chk("R8 gear 2 before gear 3", cap[exp_n+1], {9'h04C, 16'h00F0, 16'h0040});
        chk("R7 late pulse kept", cap[exp_n+2], {9'h04C, 16'h00F0, 16'h0020});
        exp_n += 3;
        repeat (LAT + 4) @(negedge clk);

        // R6: engine busy holds back the request
        ext_busy = 1'b1;
        pulse(4'b1000);
        repeat (6) begin
            @(negedge clk);
            chk("R6 no strobe while busy", req_valid, 0);
        end
        ext_busy = 1'b0;
        wait_caps(exp_n + 1);
        chk("R6 request after busy", cap[exp_n], {9'h04C, 16'h00F0, 16'h0000});
        repeat (LAT + 4) @(negedge clk);
        chk("R9 holds after gear 4", {hold_gain, hold_hf, hold_lf}, 64'b111);
        chk("R5 no overlapping requests", overlap, 0);

        summary();
        $finish;
    end

endmodule